// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the serial front end of a register space with a 16-bit byte address. An external master selects the block with an active-low chip select and clocks it in SPI mode 0: input data is sampled on the rising edge of the serial clock and output data changes on the falling edge. Each frame begins with a 32-bit command word and continues with a data phase of one or more bytes, all inside one chip-select window. The block turns every complete data byte into a single-cycle byte read or byte write strobe toward the register array.

The serial clock, the chip select and the input data line are brought into the system clock domain through two-flop synchronizers. All decisions are taken on edges detected in that domain, so the serial clock must run well below the system clock. The address taken from the command word is the first byte address and moves up by one after each byte. Multi-byte values are therefore big-endian, with the most significant byte at the lowest address. The register array answers a read strobe in the same cycle on its read data input.

Top module: `spi_reg_slave`

## Requirements
- R1: While reset is held low, and after reset is released, `reg_wr`, `reg_rd` and `miso_oe` are low. The first frame is decoded from its command word.
- R2: Command word bits 31:29, sent first and MSB first, select the operation: 3'b010 writes and 3'b011 reads. Any other code produces no strobe and no output enable until chip select goes high.
- R3: Command word bits 20:5 give the first byte address. Bits 28:21 (upper address bits) and 4:0 (turnaround) have no effect on the strobes or the data.
- R4: In a write frame, each group of 8 data bits after the command word gives one `reg_wr` pulse, one system clock wide. `reg_wdata` holds the byte, and its first serial bit is bit 7.
- R5: The byte address starts at the command address and goes up by one after each strobe, wrapping from 16'hFFFF to 16'h0000.
- R6: In a read frame, a `reg_rd` strobe fetches the byte at the command address when the command word ends. A further strobe follows each completed data byte, so a frame of N full bytes gives N+1 strobes. Each fetched byte is shifted out on `miso` MSB first, with new bits on falling serial clock edges, so that the master samples it on the rising edges.
- R7: `miso_oe` is high only in the data phase of a read frame while chip select is low. `miso` is low whenever `miso_oe` is low.
- R8: When chip select goes high during a byte or during the command word, the partial bits are discarded and no strobe is issued for them. The next frame starts with a fresh command word.
- R9: In the data phase of a read frame, the level on `mosi` has no effect on the returned data and produces no write strobe.
- R10: `reg_wr` and `reg_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| reg_addr | output | 16 | Byte address toward the register array |
| reg_wr | output | 1 | Byte write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rd | output | 1 | Byte read strobe |
| reg_rdata | input | 8 | Byte returned by the array, valid while `reg_rd` is high |

## Verification
Write and read frames are run with data phases of one to four bytes at several start addresses, including one that crosses 16'hFFFF. The upper address bits and the turnaround field are filled with non-zero values, so a wrong field split or a missing wrap shows up in the logged write addresses or in the returned bytes. The array model returns a byte computed from the full address, so every address bit affects the result. Read frames are repeated with `mosi` held at all zeros and at all ones, which shows whether the input line leaks into the read path. The six unused opcodes, and frames cut off inside a byte or inside the command word, are each followed by a normal frame, which shows that the block drops partial bits and starts the next frame cleanly.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [7:0]    reg_wdata,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata
);
  localparam logic [4:0] ADDR_LO = 5'd5;
  localparam logic [4:0] IDX_LO  = 5'd31 - (ADDR_LO + 5'(AW) - 5'd1);
  localparam logic [4:0] IDX_HI  = 5'd31 - ADDR_LO;
  localparam logic [2:0] OP_WR   = 3'b010;
  localparam logic [2:0] OP_RD   = 3'b011;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_SKIP} phase_t;

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  logic [4:0] cnt;
  logic [2:0] op;
  logic [6:0] wsh;
  logic [7:0] tx;
  phase_t     phase;

  wire cs_act    = ~cs_q[1];
  wire mosi_s    = mosi_q[1];
  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];

  assign miso_oe = cs_act && (phase == PH_RD);
  assign miso    = miso_oe & tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      cnt       <= '0;
      op        <= '0;
      wsh       <= '0;
      tx        <= '0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (reg_wr || reg_rd) reg_addr <= reg_addr + 1'b1;
      if (reg_rd) tx <= reg_rdata;
      if (!cs_act) begin
        phase <= PH_CMD;
        cnt   <= '0;
        op    <= '0;
        wsh   <= '0;
      end else if (sclk_rise) begin
        cnt <= cnt + 1'b1;
        case (phase)
          PH_CMD: begin
            if (cnt < 5'd3) op <= {op[1:0], mosi_s};
            if (cnt >= IDX_LO && cnt <= IDX_HI) reg_addr <= {reg_addr[AW-2:0], mosi_s};
            if (cnt == 5'd31) begin
              if (op == OP_RD) begin
                phase  <= PH_RD;
                reg_rd <= 1'b1;
              end else if (op == OP_WR) begin
                phase <= PH_WR;
              end else begin
                phase <= PH_SKIP;
              end
            end
          end
          PH_WR: begin
            wsh <= {wsh[5:0], mosi_s};
            if (cnt[2:0] == 3'd7) begin
              reg_wr    <= 1'b1;
              reg_wdata <= {wsh, mosi_s};
            end
          end
          PH_RD: if (cnt[2:0] == 3'd7) reg_rd <= 1'b1;
          default: ;
        endcase
      end else if (sclk_fall && phase == PH_RD && cnt[2:0] != 3'd0) begin
        tx <= {tx[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          miso,
  input logic          miso_oe,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic          reg_rd
);
  logic [2:0] cs_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_hi <= '0;
    else if (!cs_n) cs_hi <= '0;
    else if (cs_hi != 3'd7) cs_hi <= cs_hi + 1'b1;
  end

  // R10
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd));
  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> reg_addr == $past(reg_addr) + 1'b1);
  // R7
  quiet_miso_chk: assert property (@(posedge clk) disable iff (!rst_n) !miso_oe |-> !miso);
  // R7
  wr_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> !miso_oe);
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi >= 3'd4) |-> (!reg_wr && !reg_rd && !miso_oe));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe, reg_wr, reg_rd;
  logic [15:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] rval(input logic [15:0] a);
    return a[7:0] + 8'(a[15:8] * 3) + 8'h11;
  endfunction
  assign reg_rdata = rval(reg_addr);

  int checks = 0, fails = 0, wn = 0, rn = 0, oe_bad = 0;
  bit no_oe = 0, done = 0;
  logic [15:0] wa [0:15];
  logic [7:0]  wd [0:15];

  always @(posedge clk) begin
    if (reg_wr) begin
      wa[wn % 16] = reg_addr;
      wd[wn % 16] = reg_wdata;
      wn++;
    end
    if (reg_rd) rn++;
    if (miso_oe && no_oe) oe_bad++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcmd(input logic [2:0] op, input logic [15:0] a,
                                        input logic [7:0] junk, input logic [4:0] turn);
    return {op, junk, a, turn};
  endfunction

  task automatic frame(input logic [31:0] cmd, input int ntot, input logic [31:0] wdat,
                       output logic [31:0] rdat, output bit oe_ok);
    rdat = '0;
    oe_ok = 1;
    @(negedge clk) cs_n = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < ntot; i++) begin
      mosi = (i < 32) ? cmd[31-i] : wdat[63-i];
      repeat (H) @(negedge clk);
      sclk = 1;
      if (i >= 32) begin
        rdat[63-i] = miso;
        if (!miso_oe) oe_ok = 0;
      end
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (4*H) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, wdat;
    bit oe_ok;
    int w0, r0;
    logic [15:0] addrs [0:3];
    addrs[0] = 16'h0000; addrs[1] = 16'h1234; addrs[2] = 16'hFFFD; addrs[3] = 16'h8001;

    repeat (4) @(negedge clk);
    chk("R1", "oe in reset", miso_oe, 0);
    chk("R1", "wr in reset", reg_wr, 0);
    chk("R1", "rd in reset", reg_rd, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "strobes after reset", {reg_wr, reg_rd, miso_oe}, 0);

    // R3 R4 R5: write sweep with non-zero ignored fields
    no_oe = 1;
    for (int n = 1; n <= 4; n++) begin
      foreach (addrs[k]) begin
        wdat = 32'hA5C3_0F96 ^ (32'(n) * 32'h1357_9BDF) ^ 32'(k);
        w0 = wn;
        frame(mkcmd(3'b010, addrs[k], 8'(8'hC3 ^ n), 5'(n*7+k)), 32 + 8*n, wdat, rd, oe_ok);
        chk("R4", "write strobe count", wn - w0, n);
        for (int j = 0; j < n; j++) begin
          chk("R5", "write addr", wa[(w0+j)%16], 16'(addrs[k] + 16'(j)));
          chk("R4", "write byte", wd[(w0+j)%16], wdat[31-8*j -: 8]);
        end
      end
    end
    no_oe = 0;
    chk("R7", "oe during write frames", oe_bad, 0);

    // R6 R9: read sweep with alternating mosi fill
    for (int n = 1; n <= 4; n++) begin
      foreach (addrs[k]) begin
        for (int f = 0; f < 2; f++) begin
          w0 = wn; r0 = rn;
          frame(mkcmd(3'b011, addrs[k], 8'(8'h5A + n), 5'(31-k)), 32 + 8*n, f ? 32'hFFFF_FFFF : 32'h0, rd, oe_ok);
          for (int j = 0; j < n; j++)
            chk("R6", "read byte", rd[31-8*j -: 8], rval(16'(addrs[k] + 16'(j))));
          chk("R6", "read strobe count", rn - r0, n + 1);
          chk("R9", "no write on read", wn - w0, 0);
          chk("R7", "oe during read data", oe_ok, 1);
          chk("R7", "oe after frame", miso_oe, 0);
        end
      end
    end

    // R2: unused opcodes
    no_oe = 1;
    for (int op = 0; op < 8; op++) begin
      if (op == 2 || op == 3) continue;
      w0 = wn; r0 = rn;
      frame(mkcmd(3'(op), 16'h0042, 8'h00, 5'h00), 48, 32'hDEAD_BEEF, rd, oe_ok);
      chk("R2", "strobes for unused opcode", (wn - w0) + (rn - r0), 0);
    end
    chk("R2", "oe for unused opcode", oe_bad, 0);

    // R8: abort inside a byte, then a clean frame
    w0 = wn;
    frame(mkcmd(3'b010, 16'h0040, 8'h00, 5'h00), 32 + 16 + 5, 32'h1122_3344, rd, oe_ok);
    chk("R8", "writes on mid-byte abort", wn - w0, 2);
    w0 = wn;
    frame(mkcmd(3'b010, 16'h0050, 8'h00, 5'h00), 40, 32'h7E00_0000, rd, oe_ok);
    chk("R8", "frame after abort count", wn - w0, 1);
    chk("R8", "frame after abort addr", wa[w0%16], 16'h0050);
    chk("R8", "frame after abort data", wd[w0%16], 8'h7E);

    // R8: abort inside the command word
    w0 = wn; r0 = rn;
    frame(mkcmd(3'b010, 16'h0F0F, 8'h00, 5'h00), 20, 32'h0, rd, oe_ok);
    chk("R8", "strobes on command abort", (wn - w0) + (rn - r0), 0);
    w0 = wn;
    frame(mkcmd(3'b010, 16'h0777, 8'hFF, 5'h1F), 40, 32'h9C00_0000, rd, oe_ok);
    chk("R8", "frame after command abort", {wa[w0%16], wd[w0%16]}, {16'h0777, 8'h9C});
    chk("R7", "oe never on writes", oe_bad, 0);
    no_oe = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule